// File: doc/BRIEF.md
# Dual-Clock BCD Up/Down Counter

This block is one decimal digit of a synchronous counter in 8421 BCD. It has two count inputs, one for counting up and one for counting down. Each input is treated as a count clock. A fast system clock samples both inputs, and a rising transition on either one moves the digit by one. The count input that is not in use must rest high. An active-high master reset and an active-low parallel preset act asynchronously: they change the outputs at once, without waiting for a system-clock edge.

Two active-low terminal-count outputs follow the low phase of the active count input when the digit sits at its end value. The carry output does this at the top of the range and the borrow output does it at zero. These outputs can therefore drive the count inputs of the next digit directly. Several instances chained this way form a multi-digit decimal counter that steps all digits on the same system-clock edge.

Top module: `bcd_dual_clk_counter`

## Requirements
- R1: A rising transition on `up_i` while `dn_i` stays high adds one to `q_o`. A rising transition on `dn_i` while `up_i` stays high subtracts one. Either change appears on the system-clock edge at which the new high level is first sampled, and all four bits change together.
- R2: While `mr_i` is high, `q_o` reads 0 at once, without waiting for a clock edge. This holds whatever the count inputs, `load_n_i` and `data_i` are doing.
- R3: While `load_n_i` is low and `mr_i` is low, `q_o` equals `data_i` at once. A count edge sampled in the same cycle as the load has no effect, and the loaded value remains after `load_n_i` returns high.
- R4: `carry_n_o` equals NOT(q[0] AND q[3] AND NOT `up_i`). At count 9 it is low exactly while `up_i` is low, and it returns high when `up_i` rises.
- R5: `borrow_n_o` is low only when the count is 0 and `dn_i` is low.
- R6: If the idle count input is low, a rising transition on the other input leaves the count unchanged.
- R7: If a count input is low during a reset or a load and rises after the reset or load is released, that rise is counted.
- R8: Both terminal-count outputs are high in every state outside their own trigger condition, including the reset state with both count inputs high.
- R9: Counting up from 9 gives 0, and counting down from 0 gives 9.
- R10: A preset value from 10 to 15 steps up in plain binary (12, 13, 14, 15, then 0), which brings the digit back into the 0 to 9 range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples the count inputs |
| mr_i | input | 1 | Asynchronous master reset, active high |
| load_n_i | input | 1 | Asynchronous parallel preset, active low |
| data_i | input | 4 | Preset value |
| up_i | input | 1 | Count-up clock; counts on its rising transition |
| dn_i | input | 1 | Count-down clock; counts on its rising transition |
| q_o | output | 4 | Current BCD digit |
| carry_n_o | output | 1 | Up terminal count, active low |
| borrow_n_o | output | 1 | Down terminal count, active low |

## Verification
Two of this block's functions can land in the same system-clock cycle: a count-input rise and a preset or reset. The bench provokes this in two ways. It releases `up_i` high in the same half-period in which it pulls `load_n_i` low. It also holds a count input low across a load and across a reset, then raises that input afterwards. The result is judged on the two-digit decimal value read from two chained instances. The preset must win over the coinciding edge with no extra step afterwards, and the rise that comes after the release must count exactly once.

// File: rtl/bcd_cnt_pkg.sv
package bcd_cnt_pkg;

   // Kind of step the digit takes on a system-clock edge.
   typedef enum logic [1:0] {
      STEP_HOLD = 2'd0,
      STEP_UP   = 2'd1,
      STEP_DOWN = 2'd2
   } step_e;

   localparam int unsigned CNT_DIGIT_W_DEF = 4;
   localparam int unsigned CNT_TOP_DEF     = 9;

endpackage

// File: rtl/bcd_edge_det.sv
module bcd_edge_det #(
   parameter int unsigned N_LINES = 2,
   parameter logic        IDLE_LVL = 1'b1
) (
   input  logic               clk_i,
   input  logic               mr_i,
   input  logic [N_LINES-1:0] lvl_i,
   output logic [N_LINES-1:0] lvl_q_o,
   output logic [N_LINES-1:0] rise_o
);

   if (N_LINES < 1) begin : g_bad_lines
      $error("bcd_edge_det: N_LINES must be at least 1");
   end

   for (genvar gi = 0; gi < int'(N_LINES); gi++) begin : g_line
      logic hist_q;

      // The history restarts at the idle level, so an input held low
      // across a reset is seen rising after the reset is released.
      always_ff @(posedge clk_i or posedge mr_i) begin
         if (mr_i) hist_q <= IDLE_LVL;
         else      hist_q <= lvl_i[gi];
      end

      assign lvl_q_o[gi] = hist_q;
      assign rise_o[gi]  = lvl_i[gi] & ~hist_q;

      // A detected rise lasts one cycle (part of R1 and R7).
      assert_single_rise_R1: assert property (
         @(posedge clk_i) disable iff (mr_i)
         rise_o[gi] |=> !rise_o[gi]
      );
   end

endmodule

// File: rtl/bcd_step.sv
module bcd_step
   import bcd_cnt_pkg::*;
#(
   parameter int unsigned DIGIT_W = 4,
   parameter int unsigned TOP_VAL = 9
) (
   input  logic [DIGIT_W-1:0] cur_i,
   input  logic               up_ev_i,
   input  logic               dn_ev_i,
   output step_e              step_o,
   output logic [DIGIT_W-1:0] nxt_o
);

   localparam logic [DIGIT_W-1:0] TOP_V = DIGIT_W'(TOP_VAL);
   localparam logic [DIGIT_W-1:0] ONE_V = DIGIT_W'(1);

   if (TOP_VAL == 0 || TOP_VAL >= (1 << DIGIT_W)) begin : g_bad_top
      $error("bcd_step: TOP_VAL out of range for DIGIT_W");
   end

   always_comb begin
      step_o = STEP_HOLD;
      if (up_ev_i)      step_o = STEP_UP;
      else if (dn_ev_i) step_o = STEP_DOWN;
   end

   always_comb begin
      nxt_o = cur_i;
      unique case (step_o)
         // Above TOP_VAL the digit steps in plain binary and wraps to zero.
         STEP_UP:   nxt_o = (cur_i == TOP_V) ? '0 : cur_i + ONE_V;
         STEP_DOWN: nxt_o = (cur_i == '0) ? TOP_V : cur_i - ONE_V;
         default:   nxt_o = cur_i;
      endcase
   end

endmodule

// File: rtl/bcd_tc_gen.sv
module bcd_tc_gen #(
   parameter int unsigned DIGIT_W  = 4,
   parameter int unsigned TOP_VAL  = 9,
   parameter bit          TC_EXACT = 1'b0
) (
   input  logic [DIGIT_W-1:0] q_i,
   input  logic               up_i,
   input  logic               dn_i,
   output logic               carry_n_o,
   output logic               borrow_n_o
);

   localparam logic [DIGIT_W-1:0] TOP_V = DIGIT_W'(TOP_VAL);

   logic at_top;

   if (TC_EXACT) begin : g_exact
      // Full compare: carry only at the exact top value.
      assign at_top = (q_i == TOP_V);
   end else begin : g_sparse
      // Sparse decode: only the bits set in the top value are tested.
      assign at_top = &(q_i | ~TOP_V);
   end

   assign carry_n_o  = ~(at_top & ~up_i);
   assign borrow_n_o = ~((q_i == '0) & ~dn_i);

endmodule

// File: rtl/bcd_dual_clk_counter.sv
module bcd_dual_clk_counter
   import bcd_cnt_pkg::*;
#(
   parameter int unsigned DIGIT_W  = CNT_DIGIT_W_DEF,
   parameter int unsigned TOP_VAL  = CNT_TOP_DEF,
   parameter bit          TC_EXACT = 1'b0
) (
   input  logic               clk_i,
   input  logic               mr_i,
   input  logic               load_n_i,
   input  logic [DIGIT_W-1:0] data_i,
   input  logic               up_i,
   input  logic               dn_i,
   output logic [DIGIT_W-1:0] q_o,
   output logic               carry_n_o,
   output logic               borrow_n_o
);

   localparam int unsigned      N_LINES = 2;
   localparam int unsigned      UP_IDX  = 0;
   localparam int unsigned      DN_IDX  = 1;
   localparam logic [DIGIT_W-1:0] TOP_V = DIGIT_W'(TOP_VAL);

   if (DIGIT_W < 2) begin : g_bad_width
      $error("bcd_dual_clk_counter: DIGIT_W must be at least 2");
   end
   if (TOP_VAL == 0 || TOP_VAL >= (1 << DIGIT_W)) begin : g_bad_top
      $error("bcd_dual_clk_counter: TOP_VAL does not fit DIGIT_W");
   end

   logic [N_LINES-1:0] lvl, lvl_q, rise;
   logic               up_ev, dn_ev;
   step_e              step;
   logic [DIGIT_W-1:0] cnt_q, cnt_nxt;

   assign lvl[UP_IDX] = up_i;
   assign lvl[DN_IDX] = dn_i;

   bcd_edge_det #(
      .N_LINES  (N_LINES),
      .IDLE_LVL (1'b1)
   ) edge_i (
      .clk_i   (clk_i),
      .mr_i    (mr_i),
      .lvl_i   (lvl),
      .lvl_q_o (lvl_q),
      .rise_o  (rise)
   );

   // A rise counts only if the other input was high before and is still high.
   assign up_ev = rise[UP_IDX] & lvl[DN_IDX] & lvl_q[DN_IDX];
   assign dn_ev = rise[DN_IDX] & lvl[UP_IDX] & lvl_q[UP_IDX];

   bcd_step #(
      .DIGIT_W (DIGIT_W),
      .TOP_VAL (TOP_VAL)
   ) step_i (
      .cur_i   (cnt_q),
      .up_ev_i (up_ev),
      .dn_ev_i (dn_ev),
      .step_o  (step),
      .nxt_o   (cnt_nxt)
   );

   always_ff @(posedge clk_i or posedge mr_i) begin
      if (mr_i)           cnt_q <= '0;
      else if (!load_n_i) cnt_q <= data_i;
      else                cnt_q <= cnt_nxt;
   end

   // The asynchronous controls reach the outputs without waiting for a clock.
   always_comb begin
      if (mr_i)           q_o = '0;
      else if (!load_n_i) q_o = data_i;
      else                q_o = cnt_q;
   end

   bcd_tc_gen #(
      .DIGIT_W  (DIGIT_W),
      .TOP_VAL  (TOP_VAL),
      .TC_EXACT (TC_EXACT)
   ) tc_i (
      .q_i        (q_o),
      .up_i       (up_i),
      .dn_i       (dn_i),
      .carry_n_o  (carry_n_o),
      .borrow_n_o (borrow_n_o)
   );

   assert_count_up_R1: assert property (
      @(posedge clk_i) disable iff (mr_i || !load_n_i)
      (rise[UP_IDX] && dn_i && !rise[DN_IDX])
      |=> cnt_q == (($past(cnt_q) == TOP_V) ? '0 : $past(cnt_q) + DIGIT_W'(1))
   );

   assert_count_down_R1: assert property (
      @(posedge clk_i) disable iff (mr_i || !load_n_i)
      (rise[DN_IDX] && up_i && !rise[UP_IDX])
      |=> cnt_q == (($past(cnt_q) == '0) ? TOP_V : $past(cnt_q) - DIGIT_W'(1))
   );

   assert_idle_low_blocks_R6: assert property (
      @(posedge clk_i) disable iff (mr_i || !load_n_i)
      ((rise[UP_IDX] && !dn_i) || (rise[DN_IDX] && !up_i)) |=> $stable(cnt_q)
   );

   assert_load_holds_R3: assert property (
      @(posedge clk_i) disable iff (mr_i)
      ($past(!load_n_i) && !load_n_i) |-> cnt_q == $past(data_i)
   );

   assert_carry_at_top_R4: assert property (
      @(posedge clk_i) disable iff (mr_i)
      (q_o == TOP_V && !up_i) |-> !carry_n_o
   );

   assert_borrow_only_zero_R5: assert property (
      @(posedge clk_i) disable iff (mr_i)
      !borrow_n_o |-> (q_o == '0 && !dn_i)
   );

endmodule

// File: tb/bcd_dual_clk_counter_tb.sv
module bcd_dual_clk_counter_tb_top;

   localparam time CLK_PERIOD = 10ns;

   logic       clk = 1'b0;
   logic       mr, load_n, up, dn;
   logic [3:0] d_lo, d_hi;
   logic [3:0] q_lo, q_hi;
   logic       c_lo, b_lo, c_hi, b_hi;

   int errs   = 0;
   int checks = 0;
   int model  = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bcd_dual_clk_counter dut_i (
      .clk_i (clk), .mr_i (mr), .load_n_i (load_n), .data_i (d_lo),
      .up_i (up), .dn_i (dn), .q_o (q_lo), .carry_n_o (c_lo), .borrow_n_o (b_lo)
   );

   bcd_dual_clk_counter dut_hi_i (
      .clk_i (clk), .mr_i (mr), .load_n_i (load_n), .data_i (d_hi),
      .up_i (c_lo), .dn_i (b_lo), .q_o (q_hi), .carry_n_o (c_hi), .borrow_n_o (b_hi)
   );

   function automatic int next_up(int v);
      return (v + 1) % 100;
   endfunction

   function automatic int next_dn(int v);
      return (v + 99) % 100;
   endfunction

   function automatic int two_digit();
      return int'(q_hi) * 10 + int'(q_lo);
   endfunction

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errs++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("  Result: errors=%0d of %0d checks", errs, checks);
   endtask

   task automatic pulse_up();
      @(negedge clk) up = 1'b0;
      @(negedge clk);
      if (model % 10 == 9) check("R4 carry low at 9", int'(c_lo), 0);
      else                 check("R8 carry idle high", int'(c_lo), 1);
      up = 1'b1;
      @(negedge clk);
      model = next_up(model);
      check("R1/R9 up count", two_digit(), model);
   endtask

   task automatic pulse_dn();
      @(negedge clk) dn = 1'b0;
      @(negedge clk);
      if (model % 10 == 0) check("R5 borrow low at 0", int'(b_lo), 0);
      else                 check("R8 borrow idle high", int'(b_lo), 1);
      dn = 1'b1;
      @(negedge clk);
      model = next_dn(model);
      check("R1/R9 down count", two_digit(), model);
   endtask

   task automatic do_load(int v);
      @(negedge clk);
      d_lo = 4'(v % 10); d_hi = 4'(v / 10); load_n = 1'b0;
      #1 check("R3 preset immediate", two_digit(), v);
      @(negedge clk) load_n = 1'b1;
      model = v;
      @(negedge clk);
      check("R3 preset held", two_digit(), v);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errs++; checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         summary();
         $finish;
      end
   end

   initial begin
      int seed_v;
      mr = 1'b1; load_n = 1'b1; up = 1'b1; dn = 1'b1; d_lo = '0; d_hi = '0;
      #3;
      check("R2 reset before clock", two_digit(), 0);
      repeat (3) @(negedge clk);
      check("R2 reset value", two_digit(), 0);
      check("R8 carry high after reset", int'(c_lo), 1);
      check("R8 borrow high after reset", int'(b_lo), 1);
      mr = 1'b0;
      @(negedge clk);

      // Full climb through 99 -> 00 on the chained pair (R1, R9).
      for (int i = 0; i < 100; i++) pulse_up();
      check("R9 two-digit wrap up", two_digit(), 0);
      // 00 -> 99 and further down.
      for (int i = 0; i < 6; i++) pulse_dn();

      // R6: idle input low blocks counting; its later rise is a down count.
      @(negedge clk) dn = 1'b0;
      @(negedge clk) up = 1'b0;
      @(negedge clk) up = 1'b1;
      @(negedge clk);
      @(negedge clk);
      check("R6 idle low blocks up edge", two_digit(), model);
      dn = 1'b1;
      @(negedge clk);
      model = next_dn(model);
      check("R1 released down input counts", two_digit(), model);

      do_load(43);
      pulse_up();

      // R7: up held low across a load, rise after release counts.
      @(negedge clk) up = 1'b0;
      d_lo = 4'd2; d_hi = 4'd7; load_n = 1'b0;
      @(negedge clk) load_n = 1'b1;
      @(negedge clk);
      check("R7 load value with up low", two_digit(), 72);
      up = 1'b1;
      @(negedge clk);
      model = 73;
      check("R7 rise after load counts", two_digit(), model);

      // R3: count edge in the same cycle as a load; load wins.
      @(negedge clk) up = 1'b0;
      @(negedge clk);
      up = 1'b1; d_lo = 4'd5; d_hi = 4'd1; load_n = 1'b0;
      @(negedge clk) load_n = 1'b1;
      @(negedge clk);
      @(negedge clk);
      model = 15;
      check("R3 load beats coinciding edge", two_digit(), model);

      // R2: asynchronous reset overrides the preset, between clock edges.
      @(negedge clk);
      #1 mr = 1'b1; d_lo = 4'd8; d_hi = 4'd8; load_n = 1'b0;
      #1 check("R2 reset overrides preset", two_digit(), 0);
      @(negedge clk) load_n = 1'b1;
      // R7: up held low across reset, rise after release counts.
      up = 1'b0;
      @(negedge clk) mr = 1'b0;
      @(negedge clk) up = 1'b1;
      @(negedge clk);
      model = 1;
      check("R7 rise after reset counts", two_digit(), model);

      // R10: non-BCD preset recovers in binary steps (low digit only).
      @(negedge clk) d_lo = 4'd12; d_hi = 4'd0; load_n = 1'b0;
      @(negedge clk) load_n = 1'b1;
      for (int k = 13; k <= 16; k++) begin
         @(negedge clk) up = 1'b0;
         @(negedge clk) up = 1'b1;
         @(negedge clk);
         check("R10 non-BCD recovery", int'(q_lo), k % 16);
      end
      @(negedge clk) mr = 1'b1;
      @(negedge clk) mr = 1'b0;
      model = 0;
      @(negedge clk);

      // Constrained random mix with a fixed seed.
      seed_v = $urandom(32'd2718);
      for (int i = 0; i < 300; i++) begin
         int pick;
         pick = int'($urandom_range(15, 0));
         if (pick == 0)     do_load(int'($urandom_range(99, 0)));
         else if (pick < 8) pulse_up();
         else               pulse_dn();
      end

      done = 1'b1;
      summary();
      $finish;
   end

endmodule